// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Controller

This block is one channel of a bus-master disk DMA engine. Software programs it through a small register port. A table pointer names a list of descriptors in memory. The direction bit says whether data flows from the drive into memory or from memory to the drive. A start bit sets the engine running. The engine reads each descriptor, a buffer base dword followed by a count dword, over a memory read request port. It then moves the buffer one beat at a time over a data stream port. It stops after the descriptor whose count dword carries the end-of-table mark.

Software follows the engine through a status register. One bit is read-only and shows that the engine is moving data. Two flags, error and interrupt, stay set until software writes a one to them. Two bits hold whatever software writes and mark each of the two drives as DMA-capable. A transfer counts as good when the low three status bits read 100b: interrupt seen, engine idle, no error.

Top module: `bmide_channel`

## Requirements
- R1: After reset the command register, the status register and the table pointer all read 0, and neither mem_req nor dat_req is asserted.
- R2: Byte offset 0 holds the command register (bit 0 run, bit 3 direction), offset 2 holds the status register and offset 4 holds the 32-bit table pointer. Pointer bits [1:0] always read 0, and any other offset reads 0.
- R3: Writing the command register with bit 0 set while bit 0 is clear starts a walk. Each descriptor is two dwords: the buffer base at the table pointer, then the count dword at pointer+4. Count bits [15:0] give the byte length and bit 31 marks the last descriptor. The next descriptor sits 8 bytes further on.
- R4: For each descriptor, dat_req presents beats whose dat_addr starts at the base with bits [1:0] cleared and rises by 4 per accepted beat, until the byte count is used up. A count of 0 means 65536 bytes.
- R5: Status bit 0 reads 1 from the cycle after the start write until the last beat of the end-of-table descriptor is accepted. After that it reads 0.
- R6: Writing the command register with bit 0 clear while it is set stops the engine at once. Status bit 0 clears, and no further mem_req or dat_req is raised.
- R7: A response with mem_err on a fetch, or with dat_err on a beat, sets status bit 1 and stops the engine.
- R8: drive_irq high sets status bit 2. If a write-one-to-clear of bit 2 falls in the same cycle, the set wins.
- R9: In the status register, writing 1 to bit 1 or bit 2 clears it and writing 0 leaves it unchanged. Bits 5 and 6 are plain read/write. Bit 0 ignores writes, and bits 3, 4 and 7 read 0.
- R10: While status bit 0 is 1, a command write leaves the stored direction bit and dat_dir unchanged. dat_dir is 1 when the drive is read and memory is written.
- R11: After a run that ends normally and a drive interrupt, status bits [2:0] read 100b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| drive_irq | input | 1 | Interrupt from the drive |
| mem_req | output | 1 | Descriptor dword read request |
| mem_addr | output | 32 | Descriptor dword address |
| mem_ack | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_err | input | 1 | Read response carries a bus error |
| dat_req | output | 1 | Data beat request |
| dat_addr | output | 32 | Memory address of the beat |
| dat_dir | output | 1 | 1: drive to memory, 0: memory to drive |
| dat_ack | input | 1 | Beat accepted |
| dat_err | input | 1 | Beat completed with a bus error |

## Verification
Two events can land in the same cycle: a drive interrupt setting status bit 2, and a write-one-to-clear of that bit. The bench raises drive_irq in the very cycle it writes 1 to bit 2, then reads the bit back. A 1 passes and a 0 is judged a lost interrupt. A second collision is a command write that arrives while beats are streaming. The scoreboard then checks that every later beat still carries the direction latched at start.

// File: rtl/bmide_pkg.sv
package bmide_pkg;
   localparam int DW = 32;
   localparam logic [2:0] OFS_CMD  = 3'd0;
   localparam logic [2:0] OFS_STAT = 3'd2;
   localparam logic [2:0] OFS_PTR  = 3'd4;
   localparam int CMD_RUN  = 0;
   localparam int CMD_DIR  = 3;
   localparam int ST_ACT   = 0;
   localparam int ST_ERR   = 1;
   localparam int ST_IRQ   = 2;
   localparam int ST_CAP0  = 5;
   localparam int ST_CAP1  = 6;
   localparam int END_BIT  = 31;

   typedef enum logic [1:0] {
      ENG_IDLE,
      ENG_GET_BASE,
      ENG_GET_CNT,
      ENG_MOVE
   } eng_state_t;
endpackage

// File: rtl/bmide_regs.sv
module bmide_regs
   import bmide_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   input  logic              drive_irq,
   input  logic              eng_active,
   input  logic              eng_err,
   output logic              start_p,
   output logic              stop_p,
   output logic              dir_rd,
   output logic [ADDR_W-1:0] tbl_ptr
);
   logic              cmd_run, cmd_dir, st_err, st_irq;
   logic [1:0]        st_cap;
   logic [ADDR_W-1:2] ptr_q;
   logic              wr_cmd, wr_stat, wr_ptr;
   logic [7:0]        stat_byte, cmd_byte;

   assign wr_cmd  = reg_wr && (reg_addr == OFS_CMD);
   assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
   assign wr_ptr  = reg_wr && (reg_addr == OFS_PTR);
   assign start_p = wr_cmd && reg_wdata[CMD_RUN] && !cmd_run;
   assign stop_p  = wr_cmd && !reg_wdata[CMD_RUN] && cmd_run;
   assign dir_rd  = cmd_dir;
   assign tbl_ptr = {ptr_q, 2'b00};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_run <= 1'b0;
         cmd_dir <= 1'b0;
         st_err  <= 1'b0;
         st_irq  <= 1'b0;
         st_cap  <= '0;
         ptr_q   <= '0;
      end else begin
         if (wr_cmd) begin
            cmd_run <= reg_wdata[CMD_RUN];
            if (!eng_active) cmd_dir <= reg_wdata[CMD_DIR];
         end
         if (eng_err)                         st_err <= 1'b1;
         else if (wr_stat && reg_wdata[ST_ERR]) st_err <= 1'b0;
         if (drive_irq)                       st_irq <= 1'b1;
         else if (wr_stat && reg_wdata[ST_IRQ]) st_irq <= 1'b0;
         if (wr_stat) st_cap <= reg_wdata[ST_CAP1:ST_CAP0];
         if (wr_ptr)  ptr_q  <= reg_wdata[ADDR_W-1:2];
      end
   end

   always_comb begin
      stat_byte = '0;
      stat_byte[ST_ACT] = eng_active;
      stat_byte[ST_ERR] = st_err;
      stat_byte[ST_IRQ] = st_irq;
      stat_byte[ST_CAP1:ST_CAP0] = st_cap;
      cmd_byte = '0;
      cmd_byte[CMD_RUN] = cmd_run;
      cmd_byte[CMD_DIR] = cmd_dir;
      case (reg_addr)
         OFS_CMD:  reg_rdata = {24'd0, cmd_byte};
         OFS_STAT: reg_rdata = {24'd0, stat_byte};
         OFS_PTR:  reg_rdata = DW'(tbl_ptr);
         default:  reg_rdata = '0;
      endcase
   end

   assert_irq_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      drive_irq |=> st_irq);
   assert_w1c_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && reg_wdata[ST_ERR] && !eng_err) |=> !st_err);
   assert_cap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> $stable(st_cap));
   assert_dir_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      eng_active |=> $stable(cmd_dir));
endmodule

// File: rtl/bmide_engine.sv
module bmide_engine
   import bmide_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int LEN_W         = 16,
   parameter int BEAT_BYTES    = 4,
   parameter bit ZERO_LEN_FULL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_p,
   input  logic              stop_p,
   input  logic [ADDR_W-1:0] tbl_ptr,
   input  logic              dir_rd,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [DW-1:0]     mem_rdata,
   input  logic              mem_err,
   output logic              dat_req,
   output logic [ADDR_W-1:0] dat_addr,
   output logic              dat_dir,
   input  logic              dat_ack,
   input  logic              dat_err,
   output logic              active,
   output logic              err_set
);
   localparam int REM_W    = LEN_W + 1;
   localparam int BEAT_LSB = $clog2(BEAT_BYTES);

   eng_state_t        st;
   logic [ADDR_W-1:0] desc_ptr, buf_addr;
   logic [REM_W-1:0]  rem, rem_load;
   logic              last_desc, end_beat, mem_bad, dat_bad, beat_ok;
   logic [LEN_W-1:0]  len_field;

   assign mem_req  = (st == ENG_GET_BASE) || (st == ENG_GET_CNT);
   assign mem_addr = (st == ENG_GET_CNT) ? desc_ptr + ADDR_W'(4) : desc_ptr;
   assign dat_req  = (st == ENG_MOVE);
   assign dat_addr = buf_addr;
   assign dat_dir  = dir_rd;
   assign active   = (st != ENG_IDLE);
   assign mem_bad  = mem_req && mem_ack && mem_err;
   assign dat_bad  = dat_req && dat_ack && dat_err;
   assign beat_ok  = dat_req && dat_ack && !dat_err;
   assign err_set  = (mem_bad || dat_bad) && !stop_p;
   assign end_beat = (rem <= REM_W'(BEAT_BYTES));
   assign len_field = mem_rdata[LEN_W-1:0];

   generate
      if (ZERO_LEN_FULL) begin : g_zero_full
         assign rem_load = (len_field == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len_field};
      end else begin : g_zero_beat
         assign rem_load = (len_field == '0) ? REM_W'(BEAT_BYTES) : {1'b0, len_field};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ENG_IDLE;
         desc_ptr  <= '0;
         buf_addr  <= '0;
         rem       <= '0;
         last_desc <= 1'b0;
      end else if (stop_p) begin
         st <= ENG_IDLE;
      end else begin
         case (st)
            ENG_IDLE: if (start_p) begin
               desc_ptr <= tbl_ptr;
               st       <= ENG_GET_BASE;
            end
            ENG_GET_BASE: if (mem_ack) begin
               if (mem_err) st <= ENG_IDLE;
               else begin
                  buf_addr <= {mem_rdata[ADDR_W-1:BEAT_LSB], {BEAT_LSB{1'b0}}};
                  st       <= ENG_GET_CNT;
               end
            end
            ENG_GET_CNT: if (mem_ack) begin
               if (mem_err) st <= ENG_IDLE;
               else begin
                  rem       <= rem_load;
                  last_desc <= mem_rdata[END_BIT];
                  desc_ptr  <= desc_ptr + ADDR_W'(8);
                  st        <= ENG_MOVE;
               end
            end
            ENG_MOVE: if (dat_ack) begin
               if (dat_err) st <= ENG_IDLE;
               else begin
                  buf_addr <= buf_addr + ADDR_W'(BEAT_BYTES);
                  if (end_beat) st <= last_desc ? ENG_IDLE : ENG_GET_BASE;
                  else rem <= rem - REM_W'(BEAT_BYTES);
               end
            end
            default: st <= ENG_IDLE;
         endcase
      end
   end

   assert_err_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_bad || dat_bad) |=> !active);
   assert_stop_idles_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> !mem_req && !dat_req);
   assert_fetch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !stop_p) |=> mem_req && $stable(mem_addr));
   assert_beat_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_ok && !end_beat && !stop_p) |=> dat_req && (dat_addr == $past(dat_addr) + ADDR_W'(BEAT_BYTES)));
endmodule

// File: rtl/bmide_channel.sv
module bmide_channel
   import bmide_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int LEN_W         = 16,
   parameter int BEAT_BYTES    = 4,
   parameter bit ZERO_LEN_FULL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   input  logic              drive_irq,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [DW-1:0]     mem_rdata,
   input  logic              mem_err,
   output logic              dat_req,
   output logic [ADDR_W-1:0] dat_addr,
   output logic              dat_dir,
   input  logic              dat_ack,
   input  logic              dat_err
);
   generate
      if (ADDR_W < 16 || ADDR_W > DW) begin : g_bad_addr
         $error("ADDR_W must lie in 16..32");
      end
      if (LEN_W < 8 || LEN_W > 24) begin : g_bad_len
         $error("LEN_W must lie in 8..24");
      end
      if (BEAT_BYTES < 2 || (BEAT_BYTES & (BEAT_BYTES - 1)) != 0 || BEAT_BYTES > 8) begin : g_bad_beat
         $error("BEAT_BYTES must be 2, 4 or 8");
      end
   endgenerate

   logic              start_p, stop_p, dir_rd, eng_active, eng_err;
   logic [ADDR_W-1:0] tbl_ptr;

   bmide_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .drive_irq(drive_irq), .eng_active(eng_active), .eng_err(eng_err),
      .start_p(start_p), .stop_p(stop_p), .dir_rd(dir_rd), .tbl_ptr(tbl_ptr)
   );

   bmide_engine #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES), .ZERO_LEN_FULL(ZERO_LEN_FULL)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p),
      .tbl_ptr(tbl_ptr), .dir_rd(dir_rd),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .mem_err(mem_err),
      .dat_req(dat_req), .dat_addr(dat_addr), .dat_dir(dat_dir),
      .dat_ack(dat_ack), .dat_err(dat_err),
      .active(eng_active), .err_set(eng_err)
   );
endmodule

// File: tb/bmide_channel_test.sv
module bmide_channel_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        drive_irq = 1'b0;
   logic        mem_req, mem_ack = 1'b0, mem_err = 1'b0;
   logic [31:0] mem_addr, mem_rdata = '0;
   logic        dat_req, dat_dir, dat_ack = 1'b0, dat_err = 1'b0;
   logic [31:0] dat_addr;

   bmide_channel uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drive_irq(drive_irq),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .mem_err(mem_err),
      .dat_req(dat_req), .dat_addr(dat_addr), .dat_dir(dat_dir),
      .dat_ack(dat_ack), .dat_err(dat_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int          n_chk = 0, n_err = 0, beats = 0, cycles = 0;
   bit          strict = 1'b0, inj_mem_err = 1'b0;
   logic [31:0] tbl [logic [31:0]];
   logic [32:0] expq [$];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   // responder and scoreboard monitor
   always @(negedge clk) begin
      mem_ack   = mem_req;
      mem_err   = mem_req && inj_mem_err;
      mem_rdata = (mem_req && tbl.exists(mem_addr)) ? tbl[mem_addr] : 32'd0;
      dat_ack   = dat_req;
      dat_err   = 1'b0;
      if (dat_req) begin
         beats++;
         if (expq.size() > 0) begin
            logic [32:0] e;
            e = expq.pop_front();
            chk("R4 beat", {dat_addr}, e[31:0]);
            chk("R10 beat dir", {31'd0, dat_dir}, {31'd0, e[32]});
         end else if (strict) begin
            chk("R4 extra beat", dat_addr, 32'hFFFF_FFFF);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         report();
      end
   end

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic push_beats(logic [31:0] base, int n, logic dir);
      for (int k = 0; k < n; k++) expq.push_back({dir, base + 32'(4*k)});
   endtask

   task automatic wait_idle(int limit);
      logic [31:0] s;
      for (int k = 0; k < limit; k++) begin
         @(negedge clk);
         rd(3'd2, s);
         if (s[0] == 1'b0) break;
      end
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(3'd0, v); chk("R1 cmd", v, 32'h0);
      rd(3'd2, v); chk("R1 status", v, 32'h0);
      rd(3'd4, v); chk("R1 pointer", v, 32'h0);
      chk("R1 no requests", {30'd0, mem_req, dat_req}, 32'h0);
      rst_n = 1'b1;

      // R2 pointer alignment and unused offsets
      wr(3'd4, 32'h1234_5677);
      rd(3'd4, v); chk("R2 pointer", v, 32'h1234_5674);
      rd(3'd6, v); chk("R2 unused offset", v, 32'h0);

      // R9 status write semantics
      wr(3'd2, 32'h0000_00FF);
      rd(3'd2, v); chk("R9 caps only", v, 32'h60);

      // R3 R4 R5 two-descriptor run, drive to memory
      tbl[32'h100] = 32'h0000_2002; tbl[32'h104] = 32'h0000_0008;
      tbl[32'h108] = 32'h0000_3004; tbl[32'h10C] = 32'h8000_000C;
      wr(3'd4, 32'h100);
      strict = 1'b1;
      push_beats(32'h2000, 2, 1'b1);
      push_beats(32'h3004, 3, 1'b1);
      beats = 0;
      wr(3'd0, 32'h09);
      rd(3'd2, v); chk("R5 active after start", {31'd0, v[0]}, 32'h1);
      rd(3'd0, v); chk("R2 cmd readback", v, 32'h09);
      wait_idle(100);
      chk("R3 all beats", beats, 32'd5);
      chk("R4 queue drained", expq.size(), 32'd0);
      rd(3'd2, v); chk("R5 idle at end", {31'd0, v[0]}, 32'h0);

      // R8 R11 interrupt and completion pattern
      @(negedge clk); drive_irq = 1'b1;
      @(negedge clk); drive_irq = 1'b0;
      rd(3'd2, v); chk("R11 good pattern", {29'd0, v[2:0]}, 32'h4);
      wr(3'd2, 32'h66);
      rd(3'd2, v); chk("R9 w1c irq keeps caps", v, 32'h60);

      // R8 simultaneous set and clear
      @(negedge clk);
      reg_addr = 3'd2; reg_wdata = 32'h64; reg_wr = 1'b1; drive_irq = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; drive_irq = 1'b0;
      rd(3'd2, v); chk("R8 set beats clear", {31'd0, v[2]}, 32'h1);
      wr(3'd2, 32'h64);
      wr(3'd0, 32'h00);

      // R4 zero count = 65536 bytes; R10 direction held while active
      tbl[32'h200] = 32'h0001_0000; tbl[32'h204] = 32'h8000_0000;
      wr(3'd4, 32'h200);
      push_beats(32'h0001_0000, 16384, 1'b1);
      beats = 0;
      wr(3'd0, 32'h09);
      repeat (20) @(negedge clk);
      wr(3'd0, 32'h01);
      rd(3'd0, v); chk("R10 dir held", {31'd0, v[3]}, 32'h1);
      wait_idle(20000);
      chk("R4 zero count beats", beats, 32'd16384);
      chk("R4 zero queue drained", expq.size(), 32'd0);

      // R6 stop in mid-run, memory to drive
      strict = 1'b0;
      wr(3'd0, 32'h00);
      tbl[32'h300] = 32'h0000_4000; tbl[32'h304] = 32'h8000_0100;
      wr(3'd4, 32'h300);
      wr(3'd0, 32'h01);
      repeat (5) @(negedge clk);
      chk("R10 dir zero", {31'd0, dat_dir}, 32'h0);
      wr(3'd0, 32'h00);
      rd(3'd2, v); chk("R6 inactive", {31'd0, v[0]}, 32'h0);
      chk("R6 no requests", {30'd0, mem_req, dat_req}, 32'h0);
      beats = 0;
      repeat (5) @(negedge clk);
      chk("R6 no more beats", beats, 32'd0);

      // R7 fetch error
      inj_mem_err = 1'b1;
      wr(3'd0, 32'h01);
      @(negedge clk);
      inj_mem_err = 1'b0;
      rd(3'd2, v); chk("R7 error set", {29'd0, v[2:0]}, 32'h2);
      wr(3'd2, 32'h62);
      rd(3'd2, v); chk("R9 w1c error", v, 32'h60);

      report();
   end
endmodule